// File: doc/BRIEF.md
# Dual-Channel UART Register Layer

This block is the register layer that software sees for two serial channels. Each channel keeps five plain configuration registers, a receive holding register, a transmit holding register, and status and error-status registers. A byte stream with a valid strobe stands in for the serial pins: a byte offered on a channel's receive input lands in its receive holding register, and a byte written to the transmit holding register leaves on the channel's transmit output one cycle later. Bit timing, FIFOs and line-error detection sit outside this block.

Two fields in each channel's control register pick whether a received byte and a transmit write raise a one-cycle interrupt pulse. The data-ready flag clears as a side effect of a bus read of the receive holding register. A byte that lands while unread data is still held overwrites it and sets a sticky overrun flag. Reading the error-status register clears that flag.

The bus is a single-cycle register port. The address is split into a channel field in the upper bits and a 4-bit register index in the low bits. Read data is combinational and valid in the same cycle as `bus_rd`. Write and read side effects take place at the clock edge that ends that cycle.

Top module: `duo_uart_regs`

Register index, in `bus_addr[3:0]`; the channel number is in `bus_addr[4]` with default parameters:

| Index | Register | Access | Bits |
|---|---|---|---|
| 0 | line control | read/write | 7:0 |
| 1 | control | read/write | 11:0; rx mode 1:0, tx mode 3:2 |
| 2 | FIFO control | read/write | 7:0 |
| 3 | modem control | read/write | 7:0 |
| 4 | status | read-only | bit0 data ready, bit1 holding empty, bit2 transmitter empty |
| 5 | error status | read-only, cleared by read | bit0 overrun |
| 6 | FIFO status | read-only | reads 0 |
| 7 | modem status | read-only | reads 0 |
| 8 | transmit holding | write-only | 7:0; reads 0 |
| 9 | receive holding | read-only | 7:0 |
| 10 | baud divisor | read/write | 15:0 |
| 11-15 | unused | none | read 0 |

## Requirements
- R1: After reset each channel's status register reads 0x6, its error status reads 0, its configuration registers read 0, and `tx_valid`, `irq_rx` and `irq_tx` are low.
- R2: Line control (8 bits), control (12 bits), FIFO control (8 bits), modem control (8 bits) and baud divisor (16 bits) store the low bits of a write and read them back zero-extended.
- R3: A byte offered with `rx_valid` is stored in that channel's receive holding register (index 9) and sets status bit0 from the next cycle on.
- R4: A bus read of the receive holding register returns the held byte and clears status bit0, unless a new byte arrives on that channel in the same cycle, in which case bit0 stays set.
- R5: `irq_rx` of a channel pulses for one cycle, in the cycle after a byte arrives, exactly when that channel's control bits 1:0 equal 01 at arrival.
- R6: A write to the transmit holding register (index 8) drives `tx_valid` high for one cycle in the next cycle, with the written low byte on `tx_data`; status bits 1 and 2 read 1.
- R7: `irq_tx` of a channel pulses in the same cycle as that `tx_valid` pulse exactly when control bits 3:2 equal 01 at the time of the write.
- R8: Writes to status, error status, FIFO status, modem status and receive holding registers have no effect on what they read back.
- R9: A byte that arrives while status bit0 is set overwrites the held byte and sets error-status bit0. A read of error status clears it, except when an overrun occurs in that same cycle.
- R10: Bit 4 of the address selects the channel. An access or arriving byte on one channel leaves the other channel's registers and outputs untouched, and unused register indices read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| bus_addr | input | 5 | channel field and register index |
| bus_wr | input | 1 | write strobe |
| bus_rd | input | 1 | read strobe; has side effects |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, valid with `bus_rd`, else 0 |
| rx_valid | input | 2 | one received byte per channel bit |
| rx_data | input | 16 | received byte, channel c in bits 8c+7:8c |
| tx_valid | output | 2 | transmitted byte strobe per channel |
| tx_data | output | 16 | transmitted byte, channel c in bits 8c+7:8c |
| irq_rx | output | 2 | receive interrupt pulse per channel |
| irq_tx | output | 2 | transmit interrupt pulse per channel |

## Verification
The hardest situations to reach are collisions inside one cycle. One is an arrival while data is still held, coinciding with a read of the error status. The other is an arrival coinciding with a read of the receive holding register. In both, the new event must win over the clearing side effect. Random traffic seldom lines these up, so directed steps build them explicitly: one unread byte is left pending, and the next byte is placed in exactly the cycle of the clearing read. Around these steps, long seeded random runs mix reads, writes and arrivals on both channels. A bench model predicts every read value and output pulse.

// File: rtl/duo_uart_pkg.sv
package duo_uart_pkg;

  localparam int BYTE_W = 8;
  localparam int LCR_W  = 8;
  localparam int CTL_W  = 12;
  localparam int FCR_W  = 8;
  localparam int MCR_W  = 8;
  localparam int IDX_W  = 4;

  typedef enum logic [IDX_W-1:0] {
    IDX_LINE  = 4'd0,
    IDX_CTRL  = 4'd1,
    IDX_FIFO  = 4'd2,
    IDX_MODEM = 4'd3,
    IDX_STAT  = 4'd4,
    IDX_ERR   = 4'd5,
    IDX_FSTAT = 4'd6,
    IDX_MSTAT = 4'd7,
    IDX_TXH   = 4'd8,
    IDX_RXH   = 4'd9,
    IDX_DIV   = 4'd10
  } reg_idx_e;

  localparam int ST_READY = 0;
  localparam int ST_THRE  = 1;
  localparam int ST_TEMT  = 2;
  localparam int ER_OVER  = 0;

  localparam logic [1:0] MODE_PULSE = 2'b01;

  // receive interrupt enable: control field 1:0
  function automatic logic rx_irq_on(input logic [CTL_W-1:0] ctl);
    return ctl[1:0] == MODE_PULSE;
  endfunction

  // transmit interrupt enable: control field 3:2
  function automatic logic tx_irq_on(input logic [CTL_W-1:0] ctl);
    return ctl[3:2] == MODE_PULSE;
  endfunction

  // status word assembly
  function automatic logic [2:0] status_bits(input logic ready, input logic thre,
                                             input logic temt);
    logic [2:0] s;
    s = '0;
    s[ST_READY] = ready;
    s[ST_THRE]  = thre;
    s[ST_TEMT]  = temt;
    return s;
  endfunction

endpackage

// File: rtl/duo_uart_decode.sv
module duo_uart_decode
  import duo_uart_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int CH_W = 1
) (
  input  logic [CH_W+IDX_W-1:0] bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  output logic [NCH-1:0]        ch_wr,
  output logic [NCH-1:0]        ch_rd,
  output logic [IDX_W-1:0]      reg_idx
);

  logic [CH_W-1:0] ch_field;

  assign ch_field = bus_addr[CH_W+IDX_W-1:IDX_W];
  assign reg_idx  = bus_addr[IDX_W-1:0];

  for (genvar c = 0; c < NCH; c++) begin : g_sel
    assign ch_wr[c] = bus_wr && (ch_field == CH_W'(c));
    assign ch_rd[c] = bus_rd && (ch_field == CH_W'(c));
  end

endmodule

// File: rtl/duo_uart_chan.sv
module duo_uart_chan
  import duo_uart_pkg::*;
#(
  parameter int BUS_W = 32,
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [BUS_W-1:0]  wdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic [BUS_W-1:0]  rdata,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              irq_rx,
  output logic              irq_tx
);

  logic [LCR_W-1:0]  line_q;
  logic [CTL_W-1:0]  ctrl_q;
  logic [FCR_W-1:0]  fifo_q;
  logic [MCR_W-1:0]  modem_q;
  logic [DIV_W-1:0]  div_q;
  logic [BYTE_W-1:0] rhr_q;
  logic              ready_q;
  logic              thre_q;
  logic              temt_q;
  logic              over_q;

  // named internal events
  logic rx_over;
  logic rxh_read;
  logic err_read;
  logic tx_write;

  assign rx_over  = rx_valid && ready_q;
  assign rxh_read = rd_en && (reg_idx == IDX_RXH);
  assign err_read = rd_en && (reg_idx == IDX_ERR);
  assign tx_write = wr_en && (reg_idx == IDX_TXH);

  if (BUS_W > DIV_W) begin : g_unused
    logic unused_hi;
    assign unused_hi = ^wdata[BUS_W-1:DIV_W];
  end

  // configuration storage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q  <= '0;
      ctrl_q  <= '0;
      fifo_q  <= '0;
      modem_q <= '0;
      div_q   <= '0;
    end else if (wr_en) begin
      case (reg_idx)
        IDX_LINE:  line_q  <= wdata[LCR_W-1:0];
        IDX_CTRL:  ctrl_q  <= wdata[CTL_W-1:0];
        IDX_FIFO:  fifo_q  <= wdata[FCR_W-1:0];
        IDX_MODEM: modem_q <= wdata[MCR_W-1:0];
        IDX_DIV:   div_q   <= wdata[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  // receive side
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rhr_q   <= '0;
      ready_q <= 1'b0;
      over_q  <= 1'b0;
      irq_rx  <= 1'b0;
    end else begin
      irq_rx <= rx_valid && rx_irq_on(ctrl_q);
      if (rx_valid) begin
        rhr_q   <= rx_byte;
        ready_q <= 1'b1;
      end else if (rxh_read) begin
        ready_q <= 1'b0;
      end
      if (rx_over) over_q <= 1'b1;
      else if (err_read) over_q <= 1'b0;
    end
  end

  // transmit side
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thre_q   <= 1'b1;
      temt_q   <= 1'b1;
      tx_valid <= 1'b0;
      tx_byte  <= '0;
      irq_tx   <= 1'b0;
    end else begin
      tx_valid <= tx_write;
      irq_tx   <= tx_write && tx_irq_on(ctrl_q);
      if (tx_write) begin
        tx_byte <= wdata[BYTE_W-1:0];
        thre_q  <= 1'b1;
        temt_q  <= 1'b1;
      end
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    case (reg_idx)
      IDX_LINE:  rdata[LCR_W-1:0]  = line_q;
      IDX_CTRL:  rdata[CTL_W-1:0]  = ctrl_q;
      IDX_FIFO:  rdata[FCR_W-1:0]  = fifo_q;
      IDX_MODEM: rdata[MCR_W-1:0]  = modem_q;
      IDX_STAT:  rdata[2:0]        = status_bits(ready_q, thre_q, temt_q);
      IDX_ERR:   rdata[ER_OVER]    = over_q;
      IDX_RXH:   rdata[BYTE_W-1:0] = rhr_q;
      IDX_DIV:   rdata[DIV_W-1:0]  = div_q;
      default: ;
    endcase
  end

  // R3: arrival stores the byte and raises data-ready
  a_r3_arrival_held: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> ready_q && (rhr_q == $past(rx_byte)));

  // R4: a read with no arrival clears data-ready
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rxh_read && !rx_valid) |=> !ready_q);

  // R5: receive pulse only after an arrival in pulse mode
  a_r5_rx_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> $past(rx_valid) && ($past(ctrl_q[1:0]) == MODE_PULSE));

  // R6: transmit write emits its byte next cycle
  a_r6_tx_emit: assert property (@(posedge clk) disable iff (!rst_n)
    tx_write |=> tx_valid && (tx_byte == $past(wdata[BYTE_W-1:0])));

  // R7: transmit pulse only with an emitted byte
  a_r7_tx_pulse_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx |-> tx_valid);

  // R9: overrun is sticky
  a_r9_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rx_over |=> over_q);

  // R8: writes to the error-status slot do not alter it
  a_r8_err_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && !rx_valid && reg_idx == IDX_ERR) |=> $stable(over_q));

endmodule

// File: rtl/duo_uart_regs.sv
module duo_uart_regs
  import duo_uart_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int BUS_W  = 32,
  parameter int DIV_W  = 16,
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int ADDR_W = CH_W + IDX_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [BUS_W-1:0]      bus_wdata,
  output logic [BUS_W-1:0]      bus_rdata,
  input  logic [NCH-1:0]        rx_valid,
  input  logic [NCH*BYTE_W-1:0] rx_data,
  output logic [NCH-1:0]        tx_valid,
  output logic [NCH*BYTE_W-1:0] tx_data,
  output logic [NCH-1:0]        irq_rx,
  output logic [NCH-1:0]        irq_tx
);

  logic [NCH-1:0]   ch_wr;
  logic [NCH-1:0]   ch_rd;
  logic [IDX_W-1:0] reg_idx;
  logic [BUS_W-1:0] chan_rdata [NCH];

  duo_uart_decode #(.NCH(NCH), .CH_W(CH_W)) u_dec (
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .ch_wr    (ch_wr),
    .ch_rd    (ch_rd),
    .reg_idx  (reg_idx)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    duo_uart_chan #(.BUS_W(BUS_W), .DIV_W(DIV_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (ch_wr[c]),
      .rd_en    (ch_rd[c]),
      .reg_idx  (reg_idx),
      .wdata    (bus_wdata),
      .rx_valid (rx_valid[c]),
      .rx_byte  (rx_data[c*BYTE_W +: BYTE_W]),
      .rdata    (chan_rdata[c]),
      .tx_valid (tx_valid[c]),
      .tx_byte  (tx_data[c*BYTE_W +: BYTE_W]),
      .irq_rx   (irq_rx[c]),
      .irq_tx   (irq_tx[c])
    );

    // R10: a channel's receive pulse follows only its own arrivals
    a_r10_rx_pulse_own: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rx[c] |-> $past(rx_valid[c]));

    // R10: a channel's transmit strobe follows only a write addressed to it
    a_r10_tx_own: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid[c] |-> $past(bus_wr) && ($past(bus_addr[ADDR_W-1:IDX_W]) == CH_W'(c)));
  end

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (ch_rd[c]) bus_rdata = bus_rdata | chan_rdata[c];
    end
  end

endmodule

// File: tb/sim_duo_uart_regs.sv
`timescale 1ns/1ps
module sim_duo_uart_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  rx_valid = '0;
  logic [15:0] rx_data = '0;
  logic [1:0]  tx_valid;
  logic [15:0] tx_data;
  logic [1:0]  irq_rx;
  logic [1:0]  irq_tx;

  duo_uart_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  always #2.5 clk = ~clk;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 0;
  string force_tag = "";

  // bench model of each channel
  logic [7:0]  m_line [2];
  logic [11:0] m_ctrl [2];
  logic [7:0]  m_fifo [2];
  logic [7:0]  m_modem[2];
  logic [15:0] m_div  [2];
  logic [7:0]  m_rhr  [2];
  logic        m_rdy  [2];
  logic        m_ovr  [2];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp, input string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_read(input int ch, input int idx);
    case (idx)
      0:  return {24'd0, m_line[ch]};
      1:  return {20'd0, m_ctrl[ch]};
      2:  return {24'd0, m_fifo[ch]};
      3:  return {24'd0, m_modem[ch]};
      4:  return 32'h6 | {31'd0, m_rdy[ch]};
      5:  return {31'd0, m_ovr[ch]};
      9:  return {24'd0, m_rhr[ch]};
      10: return {16'd0, m_div[ch]};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input int idx);
    if (force_tag != "") return force_tag;
    case (idx)
      0, 1, 2, 3, 10: return "R2";
      4:    return "R4";
      5:    return "R9";
      6, 7: return "R8";
      9:    return "R3";
      default: return "R10";
    endcase
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_line[c] = '0; m_ctrl[c] = '0; m_fifo[c] = '0; m_modem[c] = '0;
      m_div[c] = '0; m_rhr[c] = '0; m_rdy[c] = 1'b0; m_ovr[c] = 1'b0;
    end
  endtask

  // one bus cycle with optional arrivals; checks read data and next-cycle outputs
  task automatic step(input int ch, input int idx, input bit wr, input bit rd,
                      input logic [31:0] wd, input logic [1:0] rxv, input logic [15:0] rxd);
    logic [1:0] e_txv, e_irx, e_itx;
    @(negedge clk);
    bus_addr  = {ch[0], idx[3:0]};
    bus_wr    = wr;
    bus_rd    = rd;
    bus_wdata = wd;
    rx_valid  = rxv;
    rx_data   = rxd;
    #1;
    if (rd) chk(bus_rdata == exp_read(ch, idx), tag_of(idx), bus_rdata, exp_read(ch, idx), "read");
    else chk(bus_rdata == 32'd0, "R10", bus_rdata, 32'd0, "idle rdata");
    for (int c = 0; c < 2; c++) begin
      e_txv[c] = wr && ch == c && idx == 8;
      e_itx[c] = e_txv[c] && m_ctrl[c][3:2] == 2'b01;
      e_irx[c] = rxv[c] && m_ctrl[c][1:0] == 2'b01;
    end
    @(posedge clk);
    #1;
    for (int c = 0; c < 2; c++) begin
      chk(tx_valid[c] == e_txv[c], "R6", {31'd0, tx_valid[c]}, {31'd0, e_txv[c]}, "tx_valid");
      if (e_txv[c])
        chk(tx_data[c*8 +: 8] == wd[7:0], "R6", {24'd0, tx_data[c*8 +: 8]}, {24'd0, wd[7:0]}, "tx_data");
      chk(irq_rx[c] == e_irx[c], "R5", {31'd0, irq_rx[c]}, {31'd0, e_irx[c]}, "irq_rx");
      chk(irq_tx[c] == e_itx[c], "R7", {31'd0, irq_tx[c]}, {31'd0, e_itx[c]}, "irq_tx");
    end
    // model update
    for (int c = 0; c < 2; c++) begin
      bit sel = (ch == c);
      if (rxv[c] && m_rdy[c]) m_ovr[c] = 1'b1;
      else if (rd && sel && idx == 5) m_ovr[c] = 1'b0;
      if (rxv[c]) begin
        m_rhr[c] = rxd[c*8 +: 8];
        m_rdy[c] = 1'b1;
      end else if (rd && sel && idx == 9) m_rdy[c] = 1'b0;
      if (wr && sel) begin
        case (idx)
          0:  m_line[c]  = wd[7:0];
          1:  m_ctrl[c]  = wd[11:0];
          2:  m_fifo[c]  = wd[7:0];
          3:  m_modem[c] = wd[7:0];
          10: m_div[c]   = wd[15:0];
          default: ;
        endcase
      end
    end
    bus_wr = 1'b0; bus_rd = 1'b0; rx_valid = '0;
  endtask

  task automatic rd_reg(input int ch, input int idx);
    step(ch, idx, 1'b0, 1'b1, 32'd0, 2'b00, 16'd0);
  endtask

  task automatic wr_reg(input int ch, input int idx, input logic [31:0] d);
    step(ch, idx, 1'b1, 1'b0, d, 2'b00, 16'd0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C));
    model_reset();
    repeat (4) @(posedge clk);
    #1;
    chk({tx_valid, irq_rx, irq_tx} == 6'd0, "R1", {26'd0, tx_valid, irq_rx, irq_tx}, 32'd0, "outputs in reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values on both channels
    force_tag = "R1";
    for (int c = 0; c < 2; c++) begin
      rd_reg(c, 4);
      rd_reg(c, 5);
      rd_reg(c, 1);
      rd_reg(c, 10);
    end
    force_tag = "";

    // R2: storage widths
    wr_reg(0, 0, 32'hFFFF_FFA5); rd_reg(0, 0);
    wr_reg(0, 1, 32'hFFFF_FFFF); rd_reg(0, 1);
    wr_reg(0, 10, 32'hDEAD_BEEF); rd_reg(0, 10);
    wr_reg(0, 1, 32'h0000_0005);

    // R3/R5: arrival in pulse mode
    step(0, 0, 1'b0, 1'b0, 32'd0, 2'b01, 16'h00A5);
    rd_reg(0, 4);
    // R4: read returns byte and clears
    rd_reg(0, 9);
    rd_reg(0, 4);
    // R6/R7: transmit with pulse
    wr_reg(0, 8, 32'h0000_003C);
    rd_reg(0, 4);
    // R5/R7: other mode values give no pulse
    wr_reg(0, 1, 32'h0000_000A);
    step(0, 0, 1'b0, 1'b0, 32'd0, 2'b01, 16'h0011);
    wr_reg(0, 8, 32'h0000_0077);
    rd_reg(0, 9);
    // R8: writes to read-only slots ignored
    force_tag = "R8";
    step(0, 0, 1'b0, 1'b0, 32'd0, 2'b01, 16'h0022);
    wr_reg(0, 4, 32'h0000_0000); rd_reg(0, 4);
    wr_reg(0, 5, 32'h0000_0001); rd_reg(0, 5);
    wr_reg(0, 9, 32'h0000_00EE); rd_reg(0, 9);
    wr_reg(0, 6, 32'hFFFF_FFFF); rd_reg(0, 6);
    wr_reg(0, 7, 32'hFFFF_FFFF); rd_reg(0, 7);
    force_tag = "";
    // R9: overrun, clear by read, and collision with clearing read
    force_tag = "R9";
    step(0, 0, 1'b0, 1'b0, 32'd0, 2'b01, 16'h0033);
    step(0, 0, 1'b0, 1'b0, 32'd0, 2'b01, 16'h0044);
    rd_reg(0, 9);
    rd_reg(0, 5);
    rd_reg(0, 5);
    step(0, 0, 1'b0, 1'b0, 32'd0, 2'b01, 16'h0055);
    step(0, 5, 1'b0, 1'b1, 32'd0, 2'b01, 16'h0066);
    rd_reg(0, 5);
    force_tag = "R4";
    step(0, 9, 1'b0, 1'b1, 32'd0, 2'b01, 16'h0077);
    rd_reg(0, 4);
    rd_reg(0, 9);
    force_tag = "";
    // R10: channel independence and unused indices
    force_tag = "R10";
    wr_reg(1, 10, 32'h0000_1234);
    rd_reg(0, 10);
    rd_reg(1, 10);
    step(1, 0, 1'b0, 1'b0, 32'd0, 2'b10, 16'h9900);
    rd_reg(0, 4);
    rd_reg(1, 4);
    rd_reg(1, 12);
    rd_reg(0, 15);
    force_tag = "";

    // seeded random traffic on both channels
    for (int i = 0; i < 4000; i++) begin
      int ch  = $urandom % 2;
      int idx = $urandom % 12;
      int op  = $urandom % 4;
      logic [31:0] wd = $urandom;
      logic [1:0]  rxv;
      rxv[0] = ($urandom % 4) == 0;
      rxv[1] = ($urandom % 4) == 0;
      if (idx == 1 && ($urandom % 2) == 1) wd[3:0] = 4'h5;
      step(ch, idx, op == 1, op >= 2, wd, rxv, 16'($urandom));
    end

    done = 1;
    summary();
    $finish;
  end

endmodule